// File: doc/BRIEF.md
# Variable-length instruction byte predecoder

This block sits between an instruction byte fetcher and the execute stage of an 8-bit processor whose instructions are one to three bytes long. Bytes arrive one per valid/ready handshake. The block groups them into complete instructions:

- It recognises the escape byte 0xCB, which sends the next byte to a second opcode table.
- It works out from the opcode pattern how many immediate bytes follow.
- It assembles those immediate bytes low byte first.

For each finished instruction it presents one record and holds it until the consumer accepts it. The record carries:

- the opcode and a prefixed flag;
- a coarse class code;
- the operand-select fields sliced from the opcode;
- a condition-present flag and a restart address;
- the immediate value and the total length in bytes.

Opcode 0x76 is reported as halt rather than as a register move. Eleven opcodes are illegal. When one of them is accepted, the block freezes: it takes no more bytes, emits no more records and raises a lock output until a synchronous reset.

Top module: `ibyte_predec`

## Requirements
- R1: On reset, out_valid is 0, lock is 0 and in_ready is 1. A pending 0xCB escape is forgotten, so a byte sent after reset is decoded as unprefixed.
- R2: out_len is 1 plus the number of immediate bytes.
  - Two immediate bytes follow: 00pp0001, 0x08, 0xC3, 0xCD, 0xEA, 0xFA, 110cc010 and 110cc100.
  - One immediate byte follows: 00rrr110, 11ooo110, 0x10, 0x18, 001cc000, 0xE0, 0xF0, 0xE8 and 0xF8.
  - Every other legal unprefixed opcode has none.
- R3: Immediate bytes are assembled little-endian. The first byte after the opcode goes to out_imm[7:0] and the second to out_imm[15:8]. With one immediate byte, out_imm[15:8] is 0. With none, out_imm is 0.
- R4: After 0xCB, the next byte is emitted as out_opcode with out_prefixed=1 and out_len=2. Its bits 7:6 pick the class: 00 gives shift/rotate/swap (13), 01 gives bit test (14), 10 gives bit clear (15) and 11 gives bit set (16).
- R5: Opcode 0x76 is emitted with class 3 and out_halt=1. Every other 01xxxxxx opcode is emitted with class 2 (register move) and out_halt=0.
- R6: Opcodes 0xD3, 0xDB, 0xDD, 0xE3, 0xE4, 0xEB, 0xEC, 0xED, 0xF4, 0xFC and 0xFD produce no record. From the cycle after one of them is accepted, lock is 1 and in_ready is 0, and no record appears until reset.
- R7: While out_valid is 1 and out_ready is 0, in_ready is 0 and the record stays unchanged.
- R8: The operand fields are slices of out_opcode:
  - out_r8_dst = bits 5:3
  - out_r8_src = bits 2:0
  - out_pair = bits 5:4
  - out_cond = bits 4:3
  - out_bit = bits 5:3
- R9: out_cond_en is 1 exactly for the unprefixed opcodes 001cc000, 110cc000, 110cc010 and 110cc100. out_rst_addr equals bits 5:3 times 8 for unprefixed 11ttt111, and is 0 otherwise.
- R10: Opcode 0x10 has class 12 and length 2. The byte after it is consumed as its immediate, even when that byte is itself a valid opcode.
- R11: Unprefixed class codes:
  - 0: the no-operation opcode
  - 1: loads
  - 4: 8/16-bit increment and decrement
  - 5: 8-bit ALU with a register or immediate operand
  - 6: 16-bit adds (00pp1001, 0xE8)
  - 7: accumulator rotate/adjust (00xxx111)
  - 8: relative and absolute jumps, including 0xE9
  - 9: calls and restarts
  - 10: returns (110cc000, 0xC9, 0xD9)
  - 11: stack push/pop (11pp0001, 11pp0101)
  - 12: 0x10, 0xF3 and 0xFB

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte present |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block takes the byte this cycle |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 8 | Opcode byte (second byte when prefixed) |
| out_prefixed | output | 1 | Instruction came after the 0xCB escape |
| out_class | output | 5 | Class code (R4, R5, R11) |
| out_len | output | 2 | Total length in bytes |
| out_imm | output | 16 | Assembled immediate |
| out_r8_dst | output | 3 | Opcode bits 5:3 |
| out_r8_src | output | 3 | Opcode bits 2:0 |
| out_pair | output | 2 | Opcode bits 5:4 |
| out_cond | output | 2 | Opcode bits 4:3 |
| out_cond_en | output | 1 | Conditional control transfer |
| out_bit | output | 3 | Bit index, opcode bits 5:3 |
| out_rst_addr | output | 8 | Restart target address |
| out_halt | output | 1 | Record is the halt opcode |
| lock | output | 1 | Illegal opcode seen, frozen until reset |

## Verification
A record becomes valid one clock edge after its last byte is taken, and it leaves on the edge where out_ready is high. The bench changes inputs and reads outputs only on the falling edge. It decides out_ready on that same falling edge, so it knows in advance which rising edge will complete the handshake and compares the record against the head of its expected queue there. Lock and the drop of in_ready are checked on the first falling edge after the illegal byte's acceptance edge and on every cycle after it. The hold rule is checked on every cycle in which a record was pending and not taken.

// File: rtl/predec_pkg.sv
package predec_pkg;

  localparam int OP_W = 8;

  typedef enum logic [4:0] {
    CL_NOP     = 5'd0,
    CL_LOAD    = 5'd1,
    CL_MOVE8   = 5'd2,
    CL_HALT    = 5'd3,
    CL_INCDEC  = 5'd4,
    CL_ALU8    = 5'd5,
    CL_ALU16   = 5'd6,
    CL_ACCOP   = 5'd7,
    CL_JUMP    = 5'd8,
    CL_CALL    = 5'd9,
    CL_RET     = 5'd10,
    CL_STACK   = 5'd11,
    CL_SYS     = 5'd12,
    CL_SHIFT   = 5'd13,
    CL_BITTEST = 5'd14,
    CL_BITRES  = 5'd15,
    CL_BITSET  = 5'd16
  } insn_class_e;

  typedef struct packed {
    insn_class_e cls;
    logic [1:0]  imm_bytes;
    logic        cond_en;
    logic        illegal;
  } op_info_t;

endpackage

// File: rtl/predec_primary_dec.sv
module predec_primary_dec
  import predec_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output op_info_t        info
);

  always_comb begin
    info.cls       = CL_NOP;
    info.imm_bytes = 2'd0;
    info.cond_en   = 1'b0;
    info.illegal   = 1'b0;
    case (op[7:6])
      2'b00: begin
        case (op[2:0])
          3'd0: begin
            if (op[5]) begin
              info.cls       = CL_JUMP;
              info.imm_bytes = 2'd1;
              info.cond_en   = 1'b1;
            end else begin
              case (op[4:3])
                2'd0: info.cls = CL_NOP;
                2'd1: begin info.cls = CL_LOAD; info.imm_bytes = 2'd2; end
                2'd2: begin info.cls = CL_SYS;  info.imm_bytes = 2'd1; end
                default: begin info.cls = CL_JUMP; info.imm_bytes = 2'd1; end
              endcase
            end
          end
          3'd1: begin
            if (op[3]) info.cls = CL_ALU16;
            else begin info.cls = CL_LOAD; info.imm_bytes = 2'd2; end
          end
          3'd2: info.cls = CL_LOAD;
          3'd6: begin info.cls = CL_LOAD; info.imm_bytes = 2'd1; end
          3'd7: info.cls = CL_ACCOP;
          default: info.cls = CL_INCDEC;
        endcase
      end
      2'b01: info.cls = (op[5:0] == 6'b110110) ? CL_HALT : CL_MOVE8;
      2'b10: info.cls = CL_ALU8;
      default: begin
        case (op[2:0])
          3'd0: begin
            if (!op[5]) begin
              info.cls     = CL_RET;
              info.cond_en = 1'b1;
            end else begin
              info.cls       = (op[4:3] == 2'b01) ? CL_ALU16 : CL_LOAD;
              info.imm_bytes = 2'd1;
            end
          end
          3'd1: begin
            if (!op[3]) info.cls = CL_STACK;
            else begin
              case (op[5:4])
                2'd2:    info.cls = CL_JUMP;
                2'd3:    info.cls = CL_LOAD;
                default: info.cls = CL_RET;
              endcase
            end
          end
          3'd2: begin
            if (!op[5]) begin
              info.cls       = CL_JUMP;
              info.imm_bytes = 2'd2;
              info.cond_en   = 1'b1;
            end else begin
              info.cls       = CL_LOAD;
              info.imm_bytes = op[3] ? 2'd2 : 2'd0;
            end
          end
          3'd3: begin
            case (op[5:3])
              3'd0:    begin info.cls = CL_JUMP; info.imm_bytes = 2'd2; end
              3'd1:    info.cls = CL_NOP;
              3'd6,
              3'd7:    info.cls = CL_SYS;
              default: info.illegal = 1'b1;
            endcase
          end
          3'd4: begin
            if (!op[5]) begin
              info.cls       = CL_CALL;
              info.imm_bytes = 2'd2;
              info.cond_en   = 1'b1;
            end else begin
              info.illegal = 1'b1;
            end
          end
          3'd5: begin
            if (!op[3]) info.cls = CL_STACK;
            else if (op[5:4] == 2'd0) begin
              info.cls       = CL_CALL;
              info.imm_bytes = 2'd2;
            end else begin
              info.illegal = 1'b1;
            end
          end
          3'd6: begin info.cls = CL_ALU8; info.imm_bytes = 2'd1; end
          default: info.cls = CL_CALL;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/predec_cb_dec.sv
module predec_cb_dec
  import predec_pkg::*;
(
  input  logic [1:0]  sel,
  output insn_class_e cls
);

  always_comb begin
    case (sel)
      2'b00:   cls = CL_SHIFT;
      2'b01:   cls = CL_BITTEST;
      2'b10:   cls = CL_BITRES;
      default: cls = CL_BITSET;
    endcase
  end

endmodule

// File: rtl/predec_imm_acc.sv
module predec_imm_acc #(
  parameter int BYTE_W = 8,
  parameter int SLOTS  = 2,
  parameter int CW     = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    load,
  input  logic [BYTE_W-1:0]       data,
  output logic [SLOTS*BYTE_W-1:0] value,
  output logic [CW-1:0]           count
);

  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (load)    count <= count + CW'(1);
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst || clear)                    q <= '0;
      else if (load && count == CW'(g))    q <= data;
    end
    assign value[g*BYTE_W +: BYTE_W] = q;
  end

  // R3: never more immediate bytes than slots
  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(SLOTS));

endmodule

// File: rtl/ibyte_predec.sv
module ibyte_predec
  import predec_pkg::*;
#(
  parameter logic [7:0] PREFIX_CODE = 8'hCB,
  parameter int         IMM_MAX     = 2,
  localparam int        IMM_W       = IMM_MAX * OP_W,
  localparam int        CW          = $clog2(IMM_MAX + 1),
  localparam int        LEN_W       = $clog2(IMM_MAX + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  in_byte,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OP_W-1:0]  out_opcode,
  output logic             out_prefixed,
  output logic [4:0]       out_class,
  output logic [LEN_W-1:0] out_len,
  output logic [IMM_W-1:0] out_imm,
  output logic [2:0]       out_r8_dst,
  output logic [2:0]       out_r8_src,
  output logic [1:0]       out_pair,
  output logic [1:0]       out_cond,
  output logic             out_cond_en,
  output logic [2:0]       out_bit,
  output logic [7:0]       out_rst_addr,
  output logic             out_halt,
  output logic             lock
);

  typedef enum logic [2:0] {ST_OPC, ST_SUB, ST_IMM, ST_EMIT, ST_LOCK} st_e;

  st_e               state;
  logic [OP_W-1:0]   op_q;
  logic              pref_q;
  insn_class_e       cls_q;
  logic [CW-1:0]     need_q;
  logic              cond_q;

  op_info_t          info;
  insn_class_e       cb_cls;
  logic [CW-1:0]     acc_count;
  logic              acc_last;
  logic              emit_done;

  predec_primary_dec u_pri (.op(in_byte), .info(info));
  predec_cb_dec      u_cb  (.sel(in_byte[7:6]), .cls(cb_cls));

  assign emit_done = (state == ST_EMIT) && out_ready;

  predec_imm_acc #(.BYTE_W(OP_W), .SLOTS(IMM_MAX), .CW(CW)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .clear (emit_done),
    .load  (in_valid && state == ST_IMM),
    .data  (in_byte),
    .value (out_imm),
    .count (acc_count)
  );

  assign acc_last = (acc_count == need_q - CW'(1));
  assign in_ready = (state == ST_OPC) || (state == ST_SUB) || (state == ST_IMM);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_OPC;
      op_q   <= '0;
      pref_q <= 1'b0;
      cls_q  <= CL_NOP;
      need_q <= '0;
      cond_q <= 1'b0;
    end else begin
      case (state)
        ST_OPC: if (in_valid) begin
          if (in_byte == PREFIX_CODE) begin
            pref_q <= 1'b1;
            state  <= ST_SUB;
          end else if (info.illegal) begin
            state  <= ST_LOCK;
          end else begin
            op_q   <= in_byte;
            cls_q  <= info.cls;
            need_q <= CW'(info.imm_bytes);
            cond_q <= info.cond_en;
            state  <= (info.imm_bytes == 2'd0) ? ST_EMIT : ST_IMM;
          end
        end
        ST_SUB: if (in_valid) begin
          op_q   <= in_byte;
          cls_q  <= cb_cls;
          need_q <= '0;
          cond_q <= 1'b0;
          state  <= ST_EMIT;
        end
        ST_IMM: if (in_valid && acc_last) state <= ST_EMIT;
        ST_EMIT: if (out_ready) begin
          pref_q <= 1'b0;
          state  <= ST_OPC;
        end
        default: state <= ST_LOCK;
      endcase
    end
  end

  assign out_valid    = (state == ST_EMIT);
  assign lock         = (state == ST_LOCK);
  assign out_opcode   = op_q;
  assign out_prefixed = pref_q;
  assign out_class    = cls_q;
  assign out_len      = pref_q ? LEN_W'(2) : LEN_W'(need_q) + LEN_W'(1);
  assign out_r8_dst   = op_q[5:3];
  assign out_r8_src   = op_q[2:0];
  assign out_pair     = op_q[5:4];
  assign out_cond     = op_q[4:3];
  assign out_bit      = op_q[5:3];
  assign out_cond_en  = cond_q;
  assign out_rst_addr = (cls_q == CL_CALL && op_q[2:0] == 3'd7) ? {2'b00, op_q[5:3], 3'b000} : 8'h00;
  assign out_halt     = out_valid && (cls_q == CL_HALT);

  // R6: lock is permanent and silences both sides
  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    lock |=> lock);
  a_r6_lock_quiet: assert property (@(posedge clk) disable iff (rst)
    lock |-> (!in_ready && !out_valid));

  // R7: an untaken record stays put
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_opcode) &&
      $stable(out_imm) && $stable(out_class) && $stable(out_len)));

  // R4: prefixed records are two bytes long
  a_r4_prefixed_len: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_prefixed) |-> (out_len == LEN_W'(2)));

  // R5: halt only for the carved-out move code
  a_r5_halt_code: assert property (@(posedge clk) disable iff (rst)
    out_halt |-> (out_opcode == 8'h76 && !out_prefixed));

  // R3: one-byte immediates leave the upper byte clear
  a_r3_imm_upper: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_prefixed && out_len == LEN_W'(2)) |-> (out_imm[IMM_W-1:OP_W] == '0));

  // R9: restart address only on calls/restarts
  a_r9_rst_class: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_rst_addr != 8'h00) |-> (out_class == 5'd9));

endmodule

// File: tb/ibyte_predec_test.sv
`timescale 1ns/1ps
module ibyte_predec_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, out_valid;
  logic out_ready = 1'b0;
  logic [7:0] out_opcode;
  logic out_prefixed;
  logic [4:0] out_class;
  logic [1:0] out_len;
  logic [15:0] out_imm;
  logic [2:0] out_r8_dst, out_r8_src, out_bit;
  logic [1:0] out_pair, out_cond;
  logic out_cond_en, out_halt, lock;
  logic [7:0] out_rst_addr;

  always #2 clk = ~clk;

  ibyte_predec uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode),
    .out_prefixed(out_prefixed), .out_class(out_class), .out_len(out_len),
    .out_imm(out_imm), .out_r8_dst(out_r8_dst), .out_r8_src(out_r8_src),
    .out_pair(out_pair), .out_cond(out_cond), .out_cond_en(out_cond_en),
    .out_bit(out_bit), .out_rst_addr(out_rst_addr), .out_halt(out_halt), .lock(lock)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic        pref;
    logic [4:0]  cls;
    logic [1:0]  len;
    logic [15:0] imm;
    logic        cond_en;
    logic [7:0]  rst_addr;
  } rec_t;

  rec_t expq[$];
  int total = 0;
  int bad = 0;
  int rmode = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_illegal(input logic [7:0] op);
    return op inside {8'hD3, 8'hDB, 8'hDD, 8'hE3, 8'hE4, 8'hEB, 8'hEC, 8'hED, 8'hF4, 8'hFC, 8'hFD};
  endfunction

  function automatic int ref_nimm(input logic [7:0] op);
    if ((op & 8'hCF) == 8'h01 ||
        op inside {8'h08, 8'hC3, 8'hCD, 8'hEA, 8'hFA, 8'hC2, 8'hCA, 8'hD2, 8'hDA,
                   8'hC4, 8'hCC, 8'hD4, 8'hDC}) return 2;
    if ((op & 8'hC7) == 8'h06 || (op & 8'hC7) == 8'hC6 ||
        op inside {8'h10, 8'h18, 8'h20, 8'h28, 8'h30, 8'h38, 8'hE0, 8'hF0, 8'hE8, 8'hF8}) return 1;
    return 0;
  endfunction

  function automatic logic [4:0] ref_cls(input logic [7:0] op);
    if (op == 8'h00) return 5'd0;
    if (op == 8'h76) return 5'd3;
    if (op[7:6] == 2'b01) return 5'd2;
    if (op[7:6] == 2'b10 || (op & 8'hC7) == 8'hC6) return 5'd5;
    if (op inside {8'h10, 8'hF3, 8'hFB}) return 5'd12;
    if ((op & 8'hC7) == 8'h07) return 5'd7;
    if ((op & 8'hC7) == 8'h04 || (op & 8'hC7) == 8'h05 || (op & 8'hC7) == 8'h03) return 5'd4;
    if ((op & 8'hCF) == 8'h09 || op == 8'hE8) return 5'd6;
    if (op inside {8'h18, 8'h20, 8'h28, 8'h30, 8'h38, 8'hC2, 8'hC3, 8'hCA, 8'hD2, 8'hDA, 8'hE9}) return 5'd8;
    if ((op & 8'hC7) == 8'hC7 || op inside {8'hC4, 8'hCC, 8'hCD, 8'hD4, 8'hDC}) return 5'd9;
    if (op inside {8'hC0, 8'hC8, 8'hC9, 8'hD0, 8'hD8, 8'hD9}) return 5'd10;
    if ((op & 8'hCB) == 8'hC1) return 5'd11;
    return 5'd1;
  endfunction

  function automatic rec_t ref_rec(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    rec_t r;
    int n;
    if (b0 == 8'hCB) begin
      r.op = b1; r.pref = 1'b1; r.cls = 5'd13 + 5'(b1[7:6]); r.len = 2'd2;
      r.imm = 16'h0; r.cond_en = 1'b0; r.rst_addr = 8'h00;
    end else begin
      n = ref_nimm(b0);
      r.op = b0; r.pref = 1'b0; r.cls = ref_cls(b0); r.len = 2'(n + 1);
      r.imm = (n == 2) ? {b2, b1} : (n == 1) ? {8'h00, b1} : 16'h0;
      r.cond_en = b0 inside {8'h20, 8'h28, 8'h30, 8'h38, 8'hC0, 8'hC8, 8'hD0, 8'hD8,
                             8'hC2, 8'hCA, 8'hD2, 8'hDA, 8'hC4, 8'hCC, 8'hD4, 8'hDC};
      r.rst_addr = ((b0 & 8'hC7) == 8'hC7) ? (b0 & 8'h38) : 8'h00;
    end
    return r;
  endfunction

  // called on a falling edge; returns on the falling edge after acceptance
  task automatic send_byte(input logic [7:0] b);
    in_byte = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_insn(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    int n;
    expq.push_back(ref_rec(b0, b1, b2));
    if (b0 == 8'hCB) begin
      send_byte(b0);
      send_byte(b1);
    end else begin
      n = ref_nimm(b0);
      send_byte(b0);
      if (n > 0) send_byte(b1);
      if (n > 1) send_byte(b2);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    expq.delete();
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor and consumer: decides out_ready for the next rising edge
  bit hold = 1'b0;
  logic [7:0] h_op;
  logic [15:0] h_imm;
  logic [4:0] h_cls;
  logic [1:0] h_len;

  always @(negedge clk) begin
    bit r;
    rec_t e;
    cyc++;
    if (rst) begin
      hold = 1'b0;
      out_ready = 1'b0;
    end else begin
      case (rmode)
        0: r = 1'b1;
        1: r = (cyc % 3) != 0;
        default: r = (cyc % 7) < 2;
      endcase
      out_ready = r;
      if (out_valid) chk(in_ready == 1'b0, "R7 in_ready low while record pending", in_ready, 0);
      if (hold) chk(out_valid && out_opcode == h_op && out_imm == h_imm && out_class == h_cls && out_len == h_len,
                    "R7 record held", out_opcode, h_op);
      if (out_valid && r) begin
        hold = 1'b0;
        if (expq.size() == 0) begin
          chk(1'b0, "R6 unexpected record", out_opcode, 0);
        end else begin
          e = expq.pop_front();
          chk(out_opcode == e.op, "R8 opcode", out_opcode, e.op);
          chk(out_prefixed == e.pref, "R4 prefixed flag", out_prefixed, e.pref);
          chk(out_class == e.cls, "R11 class", out_class, e.cls);
          chk(out_len == e.len, "R2 length", out_len, e.len);
          chk(out_imm == e.imm, "R3 immediate", out_imm, e.imm);
          chk(out_r8_dst == e.op[5:3] && out_r8_src == e.op[2:0] && out_pair == e.op[5:4] &&
              out_cond == e.op[4:3] && out_bit == e.op[5:3], "R8 operand fields",
              {out_r8_dst, out_r8_src, out_pair, out_cond, out_bit},
              {e.op[5:3], e.op[2:0], e.op[5:4], e.op[4:3], e.op[5:3]});
          chk(out_cond_en == e.cond_en, "R9 condition flag", out_cond_en, e.cond_en);
          chk(out_rst_addr == e.rst_addr, "R9 restart address", out_rst_addr, e.rst_addr);
          chk(out_halt == (!e.pref && e.op == 8'h76), "R5 halt flag", out_halt, (!e.pref && e.op == 8'h76));
          if (e.pref) chk(out_class == 5'd13 + 5'(e.op[7:6]), "R4 prefixed class", out_class, 5'd13 + 5'(e.op[7:6]));
          if (!e.pref && e.op[7:6] == 2'b01)
            chk(out_class == ((e.op == 8'h76) ? 5'd3 : 5'd2), "R5 move/halt class", out_class, (e.op == 8'h76) ? 3 : 2);
          if (!e.pref && e.op == 8'h10)
            chk(out_len == 2'd2 && out_class == 5'd12 && out_imm == e.imm, "R10 stop consumes next byte", out_imm, e.imm);
        end
      end else begin
        hold = out_valid;
        h_op = out_opcode; h_imm = out_imm; h_cls = out_class; h_len = out_len;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [7:0] bad_ops [11] = '{8'hD3, 8'hDB, 8'hDD, 8'hE3, 8'hE4, 8'hEB, 8'hEC, 8'hED, 8'hF4, 8'hFC, 8'hFD};

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(lock == 1'b0, "R1 lock after reset", lock, 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    // R1: escape pending across reset is dropped
    send_byte(8'hCB);
    do_reset();
    send_insn(8'h00, 8'h00, 8'h00);
    drain();

    // unprefixed sweep, steady consumer
    rmode = 0;
    for (int op = 0; op < 256; op++) begin
      if (op != 8'hCB && !is_illegal(8'(op)))
        send_insn(8'(op), 8'(op) ^ 8'h5A, 8'(op) + 8'h13);
    end
    drain();

    // prefixed sweep, gapped consumer
    rmode = 1;
    for (int op = 0; op < 256; op++) send_insn(8'hCB, 8'(op), 8'h00);
    drain();

    // R10, R3, R5, R7: directed cases under heavy back-pressure
    rmode = 2;
    send_insn(8'h10, 8'h76, 8'h00);
    send_insn(8'h76, 8'h00, 8'h00);
    send_insn(8'hC3, 8'h34, 8'h12);
    send_insn(8'hFA, 8'hFF, 8'h80);
    send_insn(8'hFF, 8'h00, 8'h00);
    send_insn(8'h38, 8'h80, 8'h00);
    send_insn(8'h10, 8'hCB, 8'h00);
    send_insn(8'hCB, 8'hCB, 8'h00);
    drain();

    // R6: each illegal opcode locks the block
    rmode = 0;
    foreach (bad_ops[i]) begin
      do_reset();
      send_insn(8'h3E, 8'h99, 8'h00);
      drain();
      send_byte(bad_ops[i]);
      chk(lock == 1'b1, "R6 lock raised", lock, 1);
      chk(in_ready == 1'b0, "R6 input refused", in_ready, 0);
      in_byte = 8'h00;
      in_valid = 1'b1;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        chk(!out_valid && lock && !in_ready, "R6 frozen", {out_valid, lock, in_ready}, 3'b010);
      end
      in_valid = 1'b0;
      do_reset();
      @(negedge clk);
      chk(lock == 1'b0 && in_ready == 1'b1, "R6 lock cleared by reset", {lock, in_ready}, 2'b01);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule